// File: doc/BRIEF.md
# Configuration Access Port Bridge

This block sits on the host side of a local bus. It turns CPU I/O accesses at two fixed port addresses into configuration cycles on that bus. Software first writes a 32-bit configuration address, with an enable bit, into the address port at I/O address 0x0CF8. A later access anywhere in the data-port window 0x0CFC to 0x0CFF then starts one configuration cycle. That cycle has one address phase and exactly one data phase. The block builds the address word from the stored register, picks the read or write command, and derives the byte enables from the CPU access size and its low address bits.

The CPU side is a request/acknowledge interface. The requester holds `io_req` until it sees the one-cycle `io_ack`. The bridge stalls the CPU until the addressed target completes the data phase. If no target claims the cycle within `TIMEOUT` data-phase clocks, the bridge ends the cycle, returns all ones and raises a sticky `cfg_timeout` flag. Bus signals are modelled as separate active-high inputs and outputs with an output enable for the address/data lines.

Top module: `cfg_port_bridge`

## Requirements
- R1: A write whose address falls in 0x0CF8..0x0CFB updates the byte lanes of the address register selected by the access byte enables. Bits 1:0 always read as zero. A read there returns the register, and it resets to zero.
- R2: When bit 31 of the address register is clear, a data-port access starts no bus cycle, is acknowledged one clock after the request is seen, and a read returns 0xFFFFFFFF.
- R3: In the address phase `bus_cbe` carries 4'b1010 for a data-port read and 4'b1011 for a data-port write.
- R4: The address-phase word is {8'h00, reg[23:11], reg[10:8], reg[7:2], 2'b00}: AD1:0 are zero, AD7:2 hold the doubleword index, AD10:8 the function number, AD23:11 the bus and device fields, and AD31:24 are zero.
- R5: During the data phase `bus_cbe` is an active-high byte-enable mask, bit n for lane n. It equals the size mask (io_size 0 = 4'b0001, 1 = 4'b0011, 2 or 3 = 4'b1111) shifted left by io_addr[1:0] and truncated to four bits.
- R6: Each data-port access with the enable bit set drives `bus_frame` for exactly one clock (the address phase). The next clock starts the only data phase, with `bus_irdy` high and `bus_frame` low.
- R7: The data phase lasts until `bus_devsel` and `bus_trdy` are both sampled high. `io_ack` follows in the next clock with the sampled read data. On a write, `io_wdata` (lane aligned) is driven on `bus_ad_out` with `bus_ad_oe` high.
- R8: If `bus_devsel` stays low for `TIMEOUT` data-phase clocks, the cycle ends, the access returns 0xFFFFFFFF and `cfg_timeout` is set. The flag stays set until the next address-port write.
- R9: An access to any other I/O address starts no cycle, changes no state, is acknowledged after one clock and reads 0xFFFFFFFF.
- R10: After reset `io_ack`, `bus_frame`, `bus_irdy`, `bus_ad_oe` and `cfg_timeout` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| io_req | input | 1 | CPU I/O request, held until acknowledged |
| io_we | input | 1 | 1 = write, 0 = read |
| io_addr | input | 16 | I/O byte address |
| io_size | input | 2 | 0 byte, 1 halfword, 2/3 doubleword |
| io_wdata | input | 32 | Lane-aligned write data |
| io_rdata | output | 32 | Read data, valid with io_ack |
| io_ack | output | 1 | One-cycle completion pulse |
| bus_frame | output | 1 | Address phase marker |
| bus_irdy | output | 1 | Initiator ready, high during the data phase |
| bus_cbe | output | 4 | Command in address phase, byte enables in data phase |
| bus_ad_out | output | 32 | Address word or write data |
| bus_ad_oe | output | 1 | Drive enable for bus_ad_out |
| bus_ad_in | input | 32 | Read data from target |
| bus_devsel | input | 1 | Target claims the cycle |
| bus_trdy | input | 1 | Target ready |
| cfg_timeout | output | 1 | Sticky no-response flag |

## Verification
The checker watches the bus framing on every clock. It confirms that every address phase carries a configuration command with zero low and top address bits, and that a single data phase always follows. It also confirms that no cycle starts while the enable bit is clear, that completion comes one clock after target-ready, and that the timeout flag only rises alongside an all-ones acknowledge. Register byte-lane merging, the exact address-word fields, the byte-enable mapping per size and offset, wait-state counts and the timeout length are shown only by the bench scenarios. There, a model target answers with chosen delays or stays silent.

// File: rtl/cfg_port_bridge.sv
module cfg_port_bridge #(
  parameter int          TIMEOUT   = 16,
  parameter logic [15:0] APORT     = 16'h0CF8,
  parameter logic [15:0] DPORT     = 16'h0CFC
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        io_req,
  input  logic        io_we,
  input  logic [15:0] io_addr,
  input  logic [1:0]  io_size,
  input  logic [31:0] io_wdata,
  output logic [31:0] io_rdata,
  output logic        io_ack,
  output logic        bus_frame,
  output logic        bus_irdy,
  output logic [3:0]  bus_cbe,
  output logic [31:0] bus_ad_out,
  output logic        bus_ad_oe,
  input  logic [31:0] bus_ad_in,
  input  logic        bus_devsel,
  input  logic        bus_trdy,
  output logic        cfg_timeout
);
  localparam int TW = $clog2(TIMEOUT + 1);
  localparam logic [3:0] CMD_RD = 4'b1010;
  localparam logic [3:0] CMD_WR = 4'b1011;

  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_DATA, S_DONE} st_t;

  st_t         st;
  logic [31:0] areg_q, rdata_q, wdata_q;
  logic [3:0]  cmd_q, be_q;
  logic        we_q, tflag_q;
  logic [TW-1:0] tcnt;

  logic [3:0] size_mask, be_now;
  logic       hit_a, hit_d;
  logic [31:0] aword;

  assign size_mask = (io_size == 2'd0) ? 4'b0001 : (io_size == 2'd1) ? 4'b0011 : 4'b1111;
  assign be_now    = 4'(size_mask << io_addr[1:0]);
  assign hit_a     = io_addr[15:2] == APORT[15:2];
  assign hit_d     = io_addr[15:2] == DPORT[15:2];
  assign aword     = {8'h00, areg_q[23:11], areg_q[10:8], areg_q[7:2], 2'b00};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      areg_q  <= '0;
      rdata_q <= '0;
      wdata_q <= '0;
      cmd_q   <= '0;
      be_q    <= '0;
      we_q    <= 1'b0;
      tflag_q <= 1'b0;
      tcnt    <= '0;
    end else begin
      case (st)
        S_IDLE: if (io_req) begin
          if (hit_d && areg_q[31]) begin
            cmd_q   <= io_we ? CMD_WR : CMD_RD;
            be_q    <= be_now;
            we_q    <= io_we;
            wdata_q <= io_wdata;
            st      <= S_ADDR;
          end else begin
            rdata_q <= (hit_a && !io_we) ? areg_q : 32'hFFFF_FFFF;
            if (hit_a && io_we) begin
              for (int i = 0; i < 4; i++)
                if (be_now[i]) areg_q[8*i +: 8] <= io_wdata[8*i +: 8];
              areg_q[1:0] <= 2'b00;
              tflag_q     <= 1'b0;
            end
            st <= S_DONE;
          end
        end
        S_ADDR: begin
          tcnt <= '0;
          st   <= S_DATA;
        end
        S_DATA: begin
          if (bus_devsel && bus_trdy) begin
            rdata_q <= we_q ? 32'hFFFF_FFFF : bus_ad_in;
            st      <= S_DONE;
          end else if (!bus_devsel) begin
            if (tcnt == TW'(TIMEOUT - 1)) begin
              rdata_q <= 32'hFFFF_FFFF;
              tflag_q <= 1'b1;
              st      <= S_DONE;
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign io_ack      = st == S_DONE;
  assign io_rdata    = rdata_q;
  assign bus_frame   = st == S_ADDR;
  assign bus_irdy    = st == S_DATA;
  assign bus_cbe     = (st == S_ADDR) ? cmd_q : (st == S_DATA) ? be_q : 4'b0000;
  assign bus_ad_out  = (st == S_ADDR) ? aword : (st == S_DATA && we_q) ? wdata_q : 32'h0;
  assign bus_ad_oe   = (st == S_ADDR) || (st == S_DATA && we_q);
  assign cfg_timeout = tflag_q;
endmodule

// File: rtl/cfg_port_bridge_chk.sv
module cfg_port_bridge_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] io_rdata,
  input logic        io_ack,
  input logic        bus_frame,
  input logic        bus_irdy,
  input logic [3:0]  bus_cbe,
  input logic [31:0] bus_ad_out,
  input logic        bus_devsel,
  input logic        bus_trdy,
  input logic        cfg_timeout,
  input logic [31:0] areg_q
);
  p_cfg_cmd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_frame |-> (bus_cbe == 4'b1010 || bus_cbe == 4'b1011));

  p_addr_fmt_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_frame |-> (bus_ad_out[1:0] == 2'b00 && bus_ad_out[31:24] == 8'h00));

  p_be_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_irdy |-> bus_cbe != 4'b0000);

  p_one_phase_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_frame |=> (bus_irdy && !bus_frame));

  p_enable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_frame |-> areg_q[31]);

  p_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_irdy && bus_devsel && bus_trdy) |=> (io_ack && !bus_irdy));

  p_ack_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    io_ack |=> !io_ack);

  p_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_timeout) |-> (io_ack && io_rdata == 32'hFFFF_FFFF));
endmodule

bind cfg_port_bridge cfg_port_bridge_chk u_chk (
  .clk(clk), .rst_n(rst_n), .io_rdata(io_rdata), .io_ack(io_ack),
  .bus_frame(bus_frame), .bus_irdy(bus_irdy), .bus_cbe(bus_cbe),
  .bus_ad_out(bus_ad_out), .bus_devsel(bus_devsel), .bus_trdy(bus_trdy),
  .cfg_timeout(cfg_timeout), .areg_q(areg_q)
);

// File: tb/cfg_port_bridge_bench.sv
module cfg_port_bridge_bench;
  localparam int TO = 16;
  logic clk = 0, rst_n = 0;
  logic io_req = 0, io_we = 0;
  logic [15:0] io_addr = '0;
  logic [1:0]  io_size = '0;
  logic [31:0] io_wdata = '0, io_rdata, bus_ad_out, bus_ad_in = '0;
  logic io_ack, bus_frame, bus_irdy, bus_ad_oe, cfg_timeout;
  logic [3:0] bus_cbe;
  logic bus_devsel = 0, bus_trdy = 0;

  cfg_port_bridge #(.TIMEOUT(TO)) u_cfg_port_bridge (.*);

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [31:0] expq[$];

  bit resp_on = 1;
  int resp_wait = 0, wcnt = 0;
  logic [31:0] resp_data = '0;
  int n_frame = 0, n_irdy = 0;
  logic [31:0] last_ad, last_wd;
  logic [3:0]  last_cmd, last_be;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (bus_frame) begin
      n_frame++; last_ad = bus_ad_out; last_cmd = bus_cbe; wcnt = 0;
    end
    if (bus_irdy) begin
      n_irdy++; last_be = bus_cbe; last_wd = bus_ad_oe ? bus_ad_out : 32'hx;
      bus_devsel = resp_on;
      bus_trdy   = resp_on && (wcnt >= resp_wait);
      bus_ad_in  = resp_data;
      wcnt++;
    end else begin
      bus_devsel = 0; bus_trdy = 0;
    end
  end

  always @(negedge clk) begin
    if (rst_n && io_ack && !io_we) begin
      if (expq.size() == 0) chk("R7 unexpected read ack", io_rdata, 32'hx);
      else chk("scoreboard read data", io_rdata, expq.pop_front());
    end
  end

  task automatic acc(bit we, logic [15:0] a, logic [1:0] sz, logic [31:0] wd, logic [31:0] exp);
    int n = 0;
    @(negedge clk);
    io_we = we; io_addr = a; io_size = sz; io_wdata = wd; io_req = 1;
    if (!we) expq.push_back(exp);
    do begin
      @(negedge clk); n++;
    end while (!io_ack && n < 500);
    if (n >= 500) chk("R7 ack never came", 0, 1);
    io_req = 0;
  endtask

  initial begin
    int f0, i0;
    repeat (3) @(negedge clk);
    chk("R10 ack", io_ack, 0);
    chk("R10 frame", bus_frame, 0);
    chk("R10 irdy", bus_irdy, 0);
    chk("R10 oe", bus_ad_oe, 0);
    chk("R10 timeout", cfg_timeout, 0);
    rst_n = 1;
    acc(0, 16'h0CF8, 2, 0, 32'h0);                         // R1 reset value
    f0 = n_frame;
    acc(0, 16'h0CFC, 2, 0, 32'hFFFF_FFFF);                  // R2 disabled read
    acc(1, 16'h0CFC, 2, 32'h1111_1111, 0);                  // R2 disabled write
    chk("R2 no cycle while disabled", n_frame, f0);
    acc(1, 16'h0CF8, 2, 32'h8012_3A47, 0);
    acc(0, 16'h0CF8, 2, 0, 32'h8012_3A44);                  // R1 low bits zero
    acc(1, 16'h0CF9, 0, 32'h0000_5500, 0);
    acc(0, 16'h0CF8, 2, 0, 32'h8012_5544);                  // R1 byte lane 1
    f0 = n_frame;
    acc(0, 16'h0080, 2, 0, 32'hFFFF_FFFF);                  // R9 other read
    acc(1, 16'h0CF4, 2, 32'h0, 0);                          // R9 other write
    acc(0, 16'h0CF8, 2, 0, 32'h8012_5544);
    chk("R9 no cycle", n_frame, f0);
    acc(1, 16'h0CF8, 2, 32'h8012_1D3C, 0);
    // dword read, no wait
    f0 = n_frame; i0 = n_irdy; resp_data = 32'hDEAD_BEEF; resp_wait = 0;
    acc(0, 16'h0CFC, 2, 0, 32'hDEAD_BEEF);
    chk("R3 read cmd", last_cmd, 4'b1010);
    chk("R4 address word", last_ad, 32'h0012_1D3C);
    chk("R5 dword be", last_be, 4'b1111);
    chk("R6 one frame", n_frame - f0, 1);
    chk("R6 one data cycle", n_irdy - i0, 1);
    // halfword write at offset 2
    acc(1, 16'h0CFE, 1, 32'h1234_0000, 0);
    chk("R3 write cmd", last_cmd, 4'b1011);
    chk("R5 half at 2", last_be, 4'b1100);
    chk("R7 write data", last_wd, 32'h1234_0000);
    // byte read at offset 1 with 3 wait states
    i0 = n_irdy; resp_wait = 3; resp_data = 32'h0BAD_F00D;
    acc(0, 16'h0CFD, 0, 0, 32'h0BAD_F00D);
    chk("R5 byte at 1", last_be, 4'b0010);
    chk("R7 waits for trdy", n_irdy - i0, 4);
    resp_wait = 0;
    acc(0, 16'h0CFF, 1, 0, 32'h0BAD_F00D);
    chk("R5 half at 3 truncated", last_be, 4'b1000);
    // timeout
    resp_on = 0; i0 = n_irdy;
    acc(0, 16'h0CFC, 2, 0, 32'hFFFF_FFFF);
    chk("R8 timeout length", n_irdy - i0, TO);
    chk("R8 flag set", cfg_timeout, 1);
    resp_on = 1;
    acc(0, 16'h0CFC, 2, 0, 32'h0BAD_F00D);
    chk("R8 flag sticky", cfg_timeout, 1);
    acc(1, 16'h0CF8, 2, 32'h8000_0100, 0);
    chk("R8 flag cleared", cfg_timeout, 0);
    acc(0, 16'h0CFC, 2, 0, 32'h0BAD_F00D);
    chk("R4 function field", last_ad, 32'h0000_0100);
    repeat (3) @(negedge clk);
    chk("R7 scoreboard drained", expq.size(), 0);
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule